// File: doc/BRIEF.md
# Staggered Channel Enable Sequencer

This block drives the per-channel enable lines of a bank of LED current sinks arranged as colour triplets (red, green, blue per group). Rather than switching every output on the same clock edge, it walks through the channels one at a time in a fixed order, with a programmable number of clock cycles between steps. This spreads the inrush and release currents over time, so the supply sees many small edges instead of one large surge.

The block keeps a latch of requested enables, loaded by a strobe. The target pattern is that latch while the blanking input is low, and all zeros while it is high. Any event that can change the target starts a new pass: a load strobe, or either edge of blanking. Turn-off passes are staggered the same way as turn-on passes. The walk starts at the outermost groups and moves inward, alternating between the low and high ends of the bank. A done flag shows when a pass has reached every channel.

Top module: `stagger_seq`

## Requirements
- R1: While `rst_n` is low, at the next clock edge `drive_o` becomes all zeros, the enable latch is cleared, and `done_o` becomes 1.
- R2: With `blank_i` low, once a pass has completed, `drive_o` equals the most recently loaded enable vector. Bit 1 means on.
- R3: With `blank_i` high, once a pass has completed, `drive_o` is all zeros. The enable latch keeps its contents while blanked, and it still accepts loads while blanked.
- R4: Slot p (0 to 47) updates output bit 3*k + c. Here c = p mod 3, with red at offset 0, green at 1 and blue at 2. For triplet t = p/3, k = t/2 when t is even and k = 15 - t/2 when t is odd. This gives the group order 0,15,1,14,...,7,8.
- R5: Slot p takes its target value at the clock edge STEP_CYC*(p+1) cycles after the triggering edge. Until then the bit keeps its previous value.
- R6: A pass is started by `load_i` sampled high, by a falling edge of `blank_i`, or by a rising edge of `blank_i`. A rising edge of `blank_i` gives a staggered turn-off.
- R7: A trigger during a pass restarts it from slot 0 with the latest target. No slot is applied on the edge where the restart happens, and bits already applied keep their values.
- R8: A slot whose target is 0 still uses its time position. Its output goes to, or stays, off, and later slots keep their timing.
- R9: `done_o` clears on the edge of any trigger and rises on the edge where slot 47 is applied. While `done_o` is 1 and no trigger occurs, `drive_o` does not change.
- R10: At most one bit of `drive_o` changes on any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blank_i | input | 1 | Blanking; high forces the target to all zeros |
| load_i | input | 1 | Load strobe; captures `enable_i` into the latch and starts a pass |
| enable_i | input | 48 | Requested per-channel enables |
| drive_o | output | 48 | Staggered output enables |
| done_o | output | 1 | High once every slot of the current pass has been applied |

## Verification
An all-ones load after all-zeros checks the full order and timing cycle by cycle, because each slot appears as exactly one new bit at its own edge. Walking one-hot loads isolate single slots, so a swapped position or an off-by-one delay shows as a bit appearing at the wrong cycle. Mixed patterns applied over an all-ones output check staggered turn-off and slots that stay off. Blank toggles without a load, and loads while blanked, separate the latch from the target. A reload in mid-pass checks the restart: the partial vector must be kept and the timing must begin again from slot 0.

// File: rtl/stagger_pkg.sv
// Shared constants and the slot-to-channel mapping for the staggered sequencer.
// Assumes the channel bits are laid out as group*COLORS + colour.
package stagger_pkg;

    localparam int unsigned DEF_GROUPS = 16;
    localparam int unsigned DEF_COLORS = 3;
    localparam int unsigned DEF_STEP   = 2;

    // Map a slot in the walk to the output bit it drives (outside-in order).
    function automatic int unsigned slot_bit(input int unsigned slot,
                                             input int unsigned groups,
                                             input int unsigned colors);
        int unsigned trip;
        int unsigned col;
        int unsigned grp;
        trip = slot / colors;
        col  = slot % colors;
        if ((trip % 2) == 0)
            grp = trip / 2;
        else
            grp = groups - 1 - (trip / 2);
        return grp * colors + col;
    endfunction

endpackage

// File: rtl/stg_trigger.sv
// Holds the enable latch, derives the target vector and flags pass triggers.
// Assumes blank_i and load_i are synchronous to clk.
module stg_trigger #(
    parameter int unsigned CHANS = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blank_i,
    input  logic             load_i,
    input  logic [CHANS-1:0] enable_i,
    output logic [CHANS-1:0] target_o,
    output logic             trig_o
);

    logic [CHANS-1:0] latch_q;
    logic             blank_q;

    // Capture requested enables on the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (load_i)
            latch_q <= enable_i;
    end

    // Remember last blank level; follows the pin even in reset so no false edge.
    always_ff @(posedge clk) begin
        blank_q <= blank_i;
    end

    // Target is the latch unless blanked.
    always_comb begin
        target_o = blank_i ? '0 : latch_q;
    end

    // Any load or blank edge starts a new pass.
    always_comb begin
        trig_o = load_i | (blank_i ^ blank_q);
    end

endmodule

// File: rtl/stg_pacer.sv
// Paces the walk: waits STEP cycles per slot, advances the slot index and
// reports completion. Assumes STEP >= 1.
module stg_pacer #(
    parameter int unsigned CHANS = 48,
    parameter int unsigned STEP  = 2,
    localparam int unsigned POS_W = (CHANS > 1) ? $clog2(CHANS) : 1,
    localparam int unsigned CNT_W = (STEP > 1) ? $clog2(STEP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    output logic             fire_o,
    output logic [POS_W-1:0] pos_o,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [POS_W-1:0] pos_q;
    logic             active_q;
    logic             done_q;
    logic             last_tick;

    // Delay counter has reached the end of the current step.
    always_comb begin
        last_tick = (cnt_q == CNT_W'(STEP - 1));
    end

    // A slot is applied at the end of a step unless a restart takes the edge.
    always_comb begin
        fire_o = active_q && last_tick && !trig_i;
    end

    // Step counter, slot index and completion state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            pos_q    <= '0;
            active_q <= 1'b0;
            done_q   <= 1'b1;
        end else if (trig_i) begin
            cnt_q    <= '0;
            pos_q    <= '0;
            active_q <= 1'b1;
            done_q   <= 1'b0;
        end else if (active_q) begin
            if (last_tick) begin
                cnt_q <= '0;
                if (pos_q == POS_W'(CHANS - 1)) begin
                    pos_q    <= '0;
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end else begin
                    pos_q <= pos_q + 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign pos_o  = pos_q;
    assign done_o = done_q;

endmodule

// File: rtl/stg_apply.sv
// Output register: on each fire, copies one target bit, chosen by the slot
// mapping, into the driven vector. Assumes pos_i < CHANS whenever fire_i is high.
module stg_apply #(
    parameter int unsigned GROUPS = 16,
    parameter int unsigned COLORS = 3,
    localparam int unsigned CHANS = GROUPS * COLORS,
    localparam int unsigned POS_W = (CHANS > 1) ? $clog2(CHANS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic [CHANS-1:0] target_i,
    output logic [CHANS-1:0] drive_o
);

    logic [CHANS-1:0] hit;
    logic [CHANS-1:0] drive_q;

    // One decoder per slot, routed to its channel bit.
    for (genvar p = 0; p < CHANS; p++) begin : g_slot
        localparam int unsigned BIT = stagger_pkg::slot_bit(p, GROUPS, COLORS);
        assign hit[BIT] = fire_i && (pos_i == POS_W'(p));
    end

    // Update only the selected channel bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drive_q <= '0;
        else
            drive_q <= (drive_q & ~hit) | (target_i & hit);
    end

    assign drive_o = drive_q;

endmodule

// File: rtl/stagger_seq.sv
// Staggered channel enable sequencer top. Ties the trigger/latch, the pacer
// and the output register together. Assumes all inputs are synchronous to clk.
module stagger_seq #(
    parameter int unsigned GROUPS   = stagger_pkg::DEF_GROUPS,
    parameter int unsigned COLORS   = stagger_pkg::DEF_COLORS,
    parameter int unsigned STEP_CYC = stagger_pkg::DEF_STEP,
    localparam int unsigned CHANS   = GROUPS * COLORS,
    localparam int unsigned POS_W   = (CHANS > 1) ? $clog2(CHANS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blank_i,
    input  logic             load_i,
    input  logic [CHANS-1:0] enable_i,
    output logic [CHANS-1:0] drive_o,
    output logic             done_o
);

    logic [CHANS-1:0] target;
    logic             trig;
    logic             fire;
    logic [POS_W-1:0] pos;

    stg_trigger #(.CHANS(CHANS)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .blank_i  (blank_i),
        .load_i   (load_i),
        .enable_i (enable_i),
        .target_o (target),
        .trig_o   (trig)
    );

    stg_pacer #(.CHANS(CHANS), .STEP(STEP_CYC)) u_pace (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig),
        .fire_o (fire),
        .pos_o  (pos),
        .done_o (done_o)
    );

    stg_apply #(.GROUPS(GROUPS), .COLORS(COLORS)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire),
        .pos_i    (pos),
        .target_i (target),
        .drive_o  (drive_o)
    );

endmodule

// File: rtl/stagger_seq_chk.sv
// Port-level checker for stagger_seq, attached by bind.
module stagger_seq_chk #(
    parameter int unsigned CHANS = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             blank_i,
    input logic             load_i,
    input logic [CHANS-1:0] drive_o,
    input logic             done_o
);

    // R3
    blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && blank_i && $past(blank_i)) |-> (drive_o == '0));

    // R10
    single_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(drive_o ^ $past(drive_o)) <= 1);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_i && (blank_i == $past(blank_i))) |=> $stable(drive_o));

    // R6
    load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !done_o);

    // R6
    blank_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_i != $past(blank_i)) |=> !done_o);

endmodule

bind stagger_seq stagger_seq_chk #(.CHANS(CHANS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .blank_i (blank_i),
    .load_i  (load_i),
    .drive_o (drive_o),
    .done_o  (done_o)
);

// File: tb/stagger_seq_test.sv
module stagger_seq_test;

    localparam int GROUPS = 16;
    localparam int COLORS = 3;
    localparam int STEP   = 2;
    localparam int CHANS  = GROUPS * COLORS;
    localparam int SPAN   = CHANS * STEP;
    localparam int FULL   = SPAN + 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             blank;
    logic             load;
    logic [CHANS-1:0] data;
    logic [CHANS-1:0] drv;
    logic             done;

    int errors = 0;
    int checks = 0;
    bit ended  = 0;
    logic [CHANS-1:0] prev_drv;

    always #10 clk = ~clk;

    stagger_seq #(.GROUPS(GROUPS), .COLORS(COLORS), .STEP_CYC(STEP)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .blank_i  (blank),
        .load_i   (load),
        .enable_i (data),
        .drive_o  (drv),
        .done_o   (done)
    );

    // Slot of an output bit (inverse of the walk order, R4).
    function automatic int slot_of(int b);
        int k, c, t;
        k = b / COLORS;
        c = b % COLORS;
        t = (k < GROUPS / 2) ? 2 * k : 2 * (GROUPS - 1 - k) + 1;
        return t * COLORS + c;
    endfunction

    // Expected vector m cycles after a trigger (R5).
    function automatic logic [CHANS-1:0] exp_at(logic [CHANS-1:0] o,
                                                logic [CHANS-1:0] t, int m);
        logic [CHANS-1:0] e;
        for (int b = 0; b < CHANS; b++)
            e[b] = ((slot_of(b) + 1) * STEP <= m) ? t[b] : o[b];
        return e;
    endfunction

    task automatic chk(string tag, logic [CHANS-1:0] act, logic [CHANS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle window after a trigger; ends on the next unchecked negedge.
    task automatic window(string tag, logic [CHANS-1:0] o, logic [CHANS-1:0] t, int n);
        for (int m = 0; m < n; m++) begin
            chk(tag, drv, exp_at(o, t, m));
            chk("R9", {{(CHANS-1){1'b0}}, done}, {{(CHANS-1){1'b0}}, (m >= SPAN)});
            if (m > 0)
                chk("R10", {{(CHANS-1){1'b0}}, ($countones(drv ^ prev_drv) <= 1)},
                    {{(CHANS-1){1'b0}}, 1'b1});
            prev_drv = drv;
            @(negedge clk);
        end
    endtask

    task automatic fire_load(logic [CHANS-1:0] v);
        load = 1'b1;
        data = v;
        @(posedge clk);
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic set_blank(logic v);
        blank = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [CHANS-1:0] ones, p1, p2, p3, part, prev;
        int bits [6] = '{0, 1, 2, 45, 24, 47};
        ones = '1;
        p1 = 48'hA5A5_0F0F_3C3C;
        p2 = 48'h1234_5678_9ABC;
        p3 = 48'hFEDC_0001_8000;
        rst_n = 1'b0; blank = 1'b1; load = 1'b0; data = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", drv, '0);
        chk("R1", {{(CHANS-1){1'b0}}, done}, {{(CHANS-1){1'b0}}, 1'b1});
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", drv, '0);

        set_blank(1'b0);
        window("R6", '0, '0, FULL);          // falling blank with empty latch
        fire_load(ones);
        window("R4", '0, ones, FULL);         // full order and timing
        fire_load(p1);
        window("R8", ones, p1, FULL);         // staggered turn-off of zero slots
        set_blank(1'b1);
        window("R3", p1, '0, FULL);           // rising blank turn-off
        fire_load(p2);
        window("R3", '0, '0, FULL);           // load while blanked stays dark
        set_blank(1'b0);
        window("R2", '0, p2, FULL);           // latch kept, blank low follows it
        set_blank(1'b1);
        window("R6", p2, '0, FULL);
        set_blank(1'b0);
        window("R2", '0, p2, FULL);
        chk("R2", drv, p2);

        fire_load(ones);
        window("R7", p2, ones, 9);            // interrupted pass
        part = exp_at(p2, ones, 9);
        fire_load(p3);
        window("R7", part, p3, FULL);         // restart from slot 0

        fire_load('0);
        window("R8", p3, '0, FULL);
        prev = '0;
        foreach (bits[i]) begin
            logic [CHANS-1:0] oh;
            oh = '0;
            oh[bits[i]] = 1'b1;
            fire_load(oh);
            window("R5", prev, oh, FULL);     // single slot isolation
            prev = oh;
        end
        finish_run();
    end

endmodule